// File: doc/BRIEF.md
# Power-On Reset Configuration Sequencer

This block steps a chip through its power-on reset flow using one clock. A qualified power-on reset release starts the flow. At that release the block records two things: whether hardware configuration is enabled, and whether the chip acts as configuration master or slave. A configuration window of fixed length follows. At its end the block latches the clock-mode pins, together with two bits of the configuration word.

Next come a PLL lock wait and, unless the configuration word bypasses it, a DLL lock wait. Both are timed by an internal counter, so no analog model is needed. After the last lock, the hard reset output is released first and the soft reset output a few cycles later. Every phase length is a parameter. The power-on reset input is assumed to be already synchronous to `clk`.

The sequencer has seven states:
- `S_IDLE` holds every reset.
- `S_CFG` is the configuration window.
- `S_PLL` and `S_DLL` are the lock waits.
- `S_HREL` is the hard-reset extension.
- `S_SREL` is the soft-reset gap.
- `S_DONE` is the final state.

The transitions are:
- IDLE to CFG on a qualified release.
- CFG to PLL when the window expires.
- PLL to DLL, or PLL to HREL when the DLL is bypassed.
- DLL to HREL.
- HREL to SREL.
- SREL to DONE.
- Any state to IDLE whenever `por_n` is sampled low.

Top module: `por_cfg_seq`

## Requirements
- R1: At the first clock edge that samples `por_n` low, the block goes back to `S_IDLE`, and it stays there while `por_n` is low. After that edge, `hreset_n`, `sreset_n`, `pll_locked`, `dll_locked`, `done`, `hw_cfg_en` and `cfg_master` are all 0.
- R2: A release qualifies only if at least MIN_LOW consecutive clock edges sampled `por_n` low. A shorter low pulse starts no sequence, and both resets stay asserted until a qualifying pulse arrives.
- R3: `hw_cfg_en` is the inverse of `cfg_en_n` as sampled at the first edge that sees `por_n` high after a qualifying pulse (edge 0). Later changes of `cfg_en_n` do not alter it.
- R4: `cfg_master` is 1 only when `hw_cfg_en` is 1 and `cfg_sel` was sampled low at edge 0. `cfg_sel` high means slave (0). The value is held for the rest of the sequence.
- R5: The configuration window lasts CFG_LEN cycles. At edge CFG_LEN the block latches `modck_lat = {cw_modck_hi, modck_pins}` and also latches `cw_dll_dis`. Input values at other edges have no effect.
- R6: `pll_locked` first reads 1 after edge CFG_LEN+PLL_LEN.
- R7: With `cw_dll_dis` latched as 0, `dll_locked` first reads 1 after edge CFG_LEN+PLL_LEN+DLL_LEN. Call the lock edge L. In this case L is that edge; otherwise L is CFG_LEN+PLL_LEN.
- R8: With `cw_dll_dis` latched as 1, the DLL phase is skipped, `dll_locked` stays 0, and every later release moves earlier by DLL_LEN cycles.
- R9: `hreset_n` first reads 1 after edge L+HREL_LEN.
- R10: `sreset_n` and `done` first read 1 after edge L+HREL_LEN+SGAP_LEN. `sreset_n` is never 1 while `hreset_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| cfg_en_n | input | 1 | Hardware configuration enable, active low |
| cfg_sel | input | 1 | Mode select: 1 slave, 0 master |
| modck_pins | input | MODCK_W | Clock-mode pins |
| cw_modck_hi | input | 1 | High clock-mode bit from the configuration word |
| cw_dll_dis | input | 1 | DLL bypass bit from the configuration word |
| hreset_n | output | 1 | Hard reset, active low |
| sreset_n | output | 1 | Soft reset, active low |
| pll_locked | output | 1 | PLL lock phase complete |
| dll_locked | output | 1 | DLL lock phase complete |
| done | output | 1 | Sequence finished |
| hw_cfg_en | output | 1 | Hardware configuration enabled |
| cfg_master | output | 1 | Configuration master selected |
| modck_lat | output | MODCK_W+1 | Latched clock mode |

## Verification
The bench drives pulses of exactly MIN_LOW and MIN_LOW-1 low edges. A qualifier that is off by one would either start on the short pulse or ignore the exact one.

The mode pins and configuration-word bits hold their true value only at edge CFG_LEN and decoy values at every other edge. A latch that samples one cycle off would therefore capture a decoy.

Each run records the exact edge at which every status and reset output first goes high, with the DLL both used and bypassed. A design that skipped the bypass, or miscounted a phase by one, would show a shifted edge.

One run aborts during the hard-reset extension. A design that failed to return to idle would keep `pll_locked` high.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CFG  = 3'd1,
        S_PLL  = 3'd2,
        S_DLL  = 3'd3,
        S_HREL = 3'd4,
        S_SREL = 3'd5,
        S_DONE = 3'd6
    } seq_st_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/por_width_qual.sv
module por_width_qual #(
    parameter int unsigned MIN_LOW = 16
) (
    input  logic clk,
    input  logic por_n,
    output logic rel_ok
);
    localparam int unsigned LW = $clog2(MIN_LOW + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            if (low_cnt != LW'(MIN_LOW))
                low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign rel_ok = por_n && (low_cnt == LW'(MIN_LOW));

    // R2
    rel_after_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        rel_ok |-> $past(!por_n));

endmodule

// File: rtl/por_phase_timer.sv
module por_phase_timer #(
    parameter int unsigned TW = 12
) (
    input  logic          clk,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/por_cfg_capture.sv
module por_cfg_capture #(
    parameter int unsigned MODCK_W = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rel_ok,
    input  logic               cfg_en_n,
    input  logic               cfg_sel,
    input  logic               cfg_end,
    input  logic [MODCK_W-1:0] modck_pins,
    input  logic               cw_modck_hi,
    input  logic               cw_dll_dis,
    output logic               hw_cfg_en,
    output logic               cfg_master,
    output logic [MODCK_W:0]   modck_lat,
    output logic               dll_bypass
);
    always_ff @(posedge clk) begin
        if (!por_n) begin
            hw_cfg_en  <= 1'b0;
            cfg_master <= 1'b0;
            modck_lat  <= '0;
            dll_bypass <= 1'b0;
        end else begin
            if (rel_ok) begin
                hw_cfg_en  <= ~cfg_en_n;
                cfg_master <= ~cfg_en_n & ~cfg_sel;
            end
            if (cfg_end) begin
                modck_lat  <= {cw_modck_hi, modck_pins};
                dll_bypass <= cw_dll_dis;
            end
        end
    end

    // R3
    hw_en_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rel_ok |=> $stable(hw_cfg_en));

    // R4
    master_needs_en_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_master |-> hw_cfg_en);

endmodule

// File: rtl/por_cfg_seq.sv
module por_cfg_seq
    import por_seq_pkg::*;
#(
    parameter int unsigned MIN_LOW  = 16,
    parameter int unsigned CFG_LEN  = 1024,
    parameter int unsigned PLL_LEN  = 800,
    parameter int unsigned DLL_LEN  = 3073,
    parameter int unsigned HREL_LEN = 512,
    parameter int unsigned SGAP_LEN = 3,
    parameter int unsigned MODCK_W  = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               cfg_en_n,
    input  logic               cfg_sel,
    input  logic [MODCK_W-1:0] modck_pins,
    input  logic               cw_modck_hi,
    input  logic               cw_dll_dis,
    output logic               hreset_n,
    output logic               sreset_n,
    output logic               pll_locked,
    output logic               dll_locked,
    output logic               done,
    output logic               hw_cfg_en,
    output logic               cfg_master,
    output logic [MODCK_W:0]   modck_lat
);
    localparam int unsigned MAX_LEN =
        max_u(max_u(max_u(CFG_LEN, PLL_LEN), max_u(DLL_LEN, HREL_LEN)), SGAP_LEN);
    localparam int unsigned TW = $clog2(MAX_LEN + 1);

    seq_st_t       st_q, st_d;
    logic          rel_ok;
    logic          tmr_load;
    logic          tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          cfg_end;
    logic          dll_bypass;

    por_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk    (clk),
        .por_n  (por_n),
        .rel_ok (rel_ok)
    );

    por_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    por_cfg_capture #(.MODCK_W(MODCK_W)) u_cap (
        .clk         (clk),
        .por_n       (por_n),
        .rel_ok      (rel_ok),
        .cfg_en_n    (cfg_en_n),
        .cfg_sel     (cfg_sel),
        .cfg_end     (cfg_end),
        .modck_pins  (modck_pins),
        .cw_modck_hi (cw_modck_hi),
        .cw_dll_dis  (cw_dll_dis),
        .hw_cfg_en   (hw_cfg_en),
        .cfg_master  (cfg_master),
        .modck_lat   (modck_lat),
        .dll_bypass  (dll_bypass)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!por_n)
            st_q <= S_IDLE;
        else
            st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (rel_ok)   st_d = S_CFG;
            S_CFG:  if (tmr_zero) st_d = S_PLL;
            S_PLL:  if (tmr_zero) st_d = dll_bypass ? S_HREL : S_DLL;
            S_DLL:  if (tmr_zero) st_d = S_HREL;
            S_HREL: if (tmr_zero) st_d = S_SREL;
            S_SREL: if (tmr_zero) st_d = S_DONE;
            S_DONE: st_d = S_DONE;
            default: st_d = S_IDLE;
        endcase
    end

    assign cfg_end  = (st_q == S_CFG) && tmr_zero;
    assign tmr_load = por_n && (st_d != st_q);

    // Phase length for the state being entered
    always_comb begin
        unique case (st_d)
            S_CFG:   tmr_val = TW'(CFG_LEN - 1);
            S_PLL:   tmr_val = TW'(PLL_LEN - 1);
            S_DLL:   tmr_val = TW'(DLL_LEN - 1);
            S_HREL:  tmr_val = TW'(HREL_LEN - 1);
            S_SREL:  tmr_val = TW'(SGAP_LEN - 1);
            default: tmr_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        hreset_n   = 1'b0;
        sreset_n   = 1'b0;
        pll_locked = 1'b0;
        dll_locked = 1'b0;
        done       = 1'b0;
        unique case (st_q)
            S_IDLE, S_CFG, S_PLL: ;
            S_DLL: pll_locked = 1'b1;
            S_HREL: begin
                pll_locked = 1'b1;
                dll_locked = !dll_bypass;
            end
            S_SREL: begin
                pll_locked = 1'b1;
                dll_locked = !dll_bypass;
                hreset_n   = 1'b1;
            end
            S_DONE: begin
                pll_locked = 1'b1;
                dll_locked = !dll_bypass;
                hreset_n   = 1'b1;
                sreset_n   = 1'b1;
                done       = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    abort_idle_chk: assert property (@(posedge clk)
        !por_n |=> (st_q == S_IDLE));

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q != S_IDLE && st_q != S_DONE && !tmr_zero) |=> (st_q == $past(st_q)));

    // R6
    pll_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pll_locked) |-> ($past(st_q) == S_PLL));

    // R8
    bypass_no_dll_chk: assert property (@(posedge clk) disable iff (!por_n)
        dll_bypass |-> !dll_locked);

    // R10
    srst_order_chk: assert property (@(posedge clk) disable iff (!por_n)
        sreset_n |-> hreset_n);

endmodule

// File: tb/por_cfg_seq_test.sv
module por_cfg_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW = 4;
    localparam int C = 10;
    localparam int P = 8;
    localparam int D = 12;
    localparam int H = 6;
    localparam int S = 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       cfg_en_n = 1'b1;
    logic       cfg_sel = 1'b1;
    logic [2:0] modck_pins = 3'd0;
    logic       cw_modck_hi = 1'b0;
    logic       cw_dll_dis = 1'b0;
    logic       hreset_n, sreset_n, pll_locked, dll_locked, done;
    logic       hw_cfg_en, cfg_master;
    logic [3:0] modck_lat;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_cfg_seq #(
        .MIN_LOW(MIN_LOW), .CFG_LEN(C), .PLL_LEN(P), .DLL_LEN(D),
        .HREL_LEN(H), .SGAP_LEN(S), .MODCK_W(3)
    ) uut (
        .clk(clk), .por_n(por_n), .cfg_en_n(cfg_en_n), .cfg_sel(cfg_sel),
        .modck_pins(modck_pins), .cw_modck_hi(cw_modck_hi), .cw_dll_dis(cw_dll_dis),
        .hreset_n(hreset_n), .sreset_n(sreset_n), .pll_locked(pll_locked),
        .dll_locked(dll_locked), .done(done), .hw_cfg_en(hw_cfg_en),
        .cfg_master(cfg_master), .modck_lat(modck_lat)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Hold por_n low for n sampling edges, then release at a negedge
    task automatic pulse_por(input int n);
        @(negedge clk) por_n = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk) por_n = 1'b1;
    endtask

    task automatic check_all_reset(input string tag);
        chk({tag, " R1 hreset_n"}, hreset_n, 0);
        chk({tag, " R1 sreset_n"}, sreset_n, 0);
        chk({tag, " R1 pll_locked"}, pll_locked, 0);
        chk({tag, " R1 dll_locked"}, dll_locked, 0);
        chk({tag, " R1 done"}, done, 0);
        chk({tag, " R1 hw_cfg_en"}, hw_cfg_en, 0);
    endtask

    task automatic t_reset();
        @(negedge clk) por_n = 1'b0;
        repeat (MIN_LOW + 2) @(posedge clk);
        #1 check_all_reset("reset");
    endtask

    // Full sequence; pins hold true values only at edge C
    task automatic t_run(input string tag, input bit en_n, input bit sel,
                         input bit dd, input logic [3:0] v);
        int pll_at = -1, dll_at = -1, hr_at = -1, sr_at = -1, dn_at = -1;
        int order_bad = 0;
        int lock = C + P + (dd ? 0 : D);
        int total = lock + H + S + 4;
        cfg_en_n = en_n;
        cfg_sel = sel;
        modck_pins = ~v[2:0];
        cw_modck_hi = ~v[3];
        cw_dll_dis = ~dd;
        pulse_por(MIN_LOW);
        for (int k = 0; k <= total; k++) begin
            @(posedge clk);
            #1;
            if (pll_locked && pll_at < 0) pll_at = k;
            if (dll_locked && dll_at < 0) dll_at = k;
            if (hreset_n && hr_at < 0) hr_at = k;
            if (sreset_n && sr_at < 0) sr_at = k;
            if (done && dn_at < 0) dn_at = k;
            if (sreset_n && !hreset_n) order_bad++;
            if (k == 0) begin
                cfg_en_n = ~en_n;
                cfg_sel = ~sel;
            end
            if (k == C - 1) begin
                modck_pins = v[2:0];
                cw_modck_hi = v[3];
                cw_dll_dis = dd;
            end
            if (k == C) begin
                modck_pins = ~v[2:0];
                cw_modck_hi = ~v[3];
                cw_dll_dis = ~dd;
            end
        end
        chk({tag, " R3 hw_cfg_en"}, hw_cfg_en, !en_n);
        chk({tag, " R4 cfg_master"}, cfg_master, (!en_n) && (!sel));
        chk({tag, " R5 modck_lat"}, modck_lat, v);
        chk({tag, " R6 pll edge"}, pll_at, C + P);
        if (dd) chk({tag, " R8 dll edge"}, dll_at, -1);
        else    chk({tag, " R7 dll edge"}, dll_at, C + P + D);
        chk({tag, " R9 hreset edge"}, hr_at, lock + H);
        chk({tag, " R10 sreset edge"}, sr_at, lock + H + S);
        chk({tag, " R10 done edge"}, dn_at, lock + H + S);
        chk({tag, " R10 order"}, order_bad, 0);
    endtask

    // Abort during hard-reset extension
    task automatic t_abort();
        cfg_en_n = 1'b0;
        cfg_sel = 1'b0;
        cw_dll_dis = 1'b0;
        pulse_por(MIN_LOW);
        for (int k = 0; k < C + P + D + 2; k++) @(posedge clk);
        #1 chk("abort pre R7 pll_locked", pll_locked, 1);
        @(negedge clk) por_n = 1'b0;
        @(posedge clk);
        #1 check_all_reset("abort");
        chk("abort R1 cfg_master", cfg_master, 0);
    endtask

    // Short pulse from finished state: no restart
    task automatic t_short();
        pulse_por(MIN_LOW - 1);
        repeat (C + P + D + H + S + 20) @(posedge clk);
        #1;
        chk("short R2 hreset_n", hreset_n, 0);
        chk("short R2 done", done, 0);
        chk("short R2 pll_locked", pll_locked, 0);
    endtask

    initial begin
        t_reset();
        t_run("runA", 1'b0, 1'b0, 1'b0, 4'b1010);
        t_run("runB", 1'b0, 1'b1, 1'b1, 4'b0101);
        t_run("runC", 1'b1, 1'b0, 1'b0, 4'b1100);
        t_abort();
        t_run("runD", 1'b0, 1'b0, 1'b1, 4'b0011);
        t_short();
        t_run("runE", 1'b1, 1'b1, 1'b1, 4'b1001);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule